// File: doc/BRIEF.md
# Subtraction-Based Magnitude Comparator

This combinational unit compares two unsigned operands of a parameterised width by running them through one shared adder-subtractor and reading the outcome off the result. In subtract mode, the second operand is inverted bit by bit and the carry into the adder is set to one. The adder then produces the first operand minus the second in two's complement.

The carry-out of the adder and a zero test on the difference give three flags: greater, less and equal. In add mode the same adder returns the plain sum and carry, and the three flags are held low.

The block has no registers. Its outputs depend only on its present inputs.

Top module: `subcmp_unit`

## Requirements
- R1: With `sub_mode` = 0, `{carry_out, result}` equals `op_a + op_b` taken as a W+1 bit unsigned sum.
- R2: With `sub_mode` = 1, `result` equals `(op_a - op_b) mod 2^W`. The adder's carry-in is 1 and `carry_out` is 1 exactly when `op_a >= op_b`.
- R3: With `sub_mode` = 1, `a_eq_b` is 1 exactly when every bit of the difference is 0, which happens exactly when `op_a == op_b`.
- R4: With `sub_mode` = 1, `a_lt_b` is 1 exactly when `carry_out` is 0, which happens exactly when `op_a < op_b`.
- R5: With `sub_mode` = 1, `a_gt_b` is 1 exactly when `carry_out` is 1 and the difference is non-zero, which happens exactly when `op_a > op_b`.
- R6: With `sub_mode` = 1, exactly one of `a_gt_b`, `a_lt_b` and `a_eq_b` is 1 for every operand pair.
- R7: With `sub_mode` = 0, `a_gt_b`, `a_lt_b` and `a_eq_b` are all 0, whatever the operands are.
- R8: The width W is a parameter (default 4). R1 to R7 hold unchanged at other widths, and the carry chain and the zero test grow with W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand (minuend in subtract mode) |
| op_b | input | W | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 1 selects subtract and compare, 0 selects add |
| result | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the most significant adder bit |
| a_gt_b | output | 1 | op_a greater than op_b (subtract mode only) |
| a_lt_b | output | 1 | op_a less than op_b (subtract mode only) |
| a_eq_b | output | 1 | op_a equal to op_b (subtract mode only) |

## Verification
The case that is hardest to reach is the borrow chain that runs the full length of the adder. This happens with operands such as zero minus all-ones, or all-ones minus all-ones, where the carry-out and the zero test must both be right at the extreme of the chain.

At the default width, the stimulus sweeps every operand pair in both modes, so every full-length carry and every zero difference is met. A second, wider instance is driven with its boundary operands (0, 1, maximum, maximum minus one) as well as pseudo-random pairs. This shows that the carry and zero logic follow the width.

// File: rtl/subcmp_pkg.sv
package subcmp_pkg;

  // One-bit sum of a full adder cell.
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // One-bit carry of a full adder cell.
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

  // Compare outcome carried between the decoder and the top.
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_flags_t;

endpackage

// File: rtl/subcmp_operand_prep.sv
module subcmp_operand_prep #(
  parameter int W = 4
) (
  input  logic [W-1:0] raw_b,
  input  logic         invert,
  output logic [W-1:0] cond_b,
  output logic         carry_seed
);
  // Each bit of the second operand is XORed with the mode bit.
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign cond_b[i] = raw_b[i] ^ invert;
  end
  // In subtract mode the carry-in supplies the +1 of the two's complement.
  assign carry_seed = invert;
endmodule

// File: rtl/subcmp_ripple_add.sv
module subcmp_ripple_add #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import subcmp_pkg::*;

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign s[i]         = fa_sum(x[i], y[i], chain[i]);
    assign chain[i + 1] = fa_carry(x[i], y[i], chain[i]);
  end

  assign cout = chain[W];
endmodule

// File: rtl/subcmp_flag_decode.sv
module subcmp_flag_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0]            diff,
  input  logic                    cout,
  input  logic                    enable,
  output logic                    is_zero,
  output subcmp_pkg::cmp_flags_t  flags
);
  // The zero detect is a NOR over all bits, so it grows with W.
  assign is_zero = ~|diff;

  always_comb begin
    flags    = '0;
    flags.eq = enable & is_zero;
    flags.lt = enable & ~cout;
    flags.gt = enable & cout & ~is_zero;
  end
endmodule

// File: rtl/subcmp_unit.sv
module subcmp_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         a_gt_b,
  output logic         a_lt_b,
  output logic         a_eq_b
);
  // Named internal events, kept visible for the bound checker.
  logic [W-1:0]           b_eff;
  logic                   cin;
  logic                   diff_zero;
  subcmp_pkg::cmp_flags_t flags;

  subcmp_operand_prep #(.W(W)) u_prep (
    .raw_b      (op_b),
    .invert     (sub_mode),
    .cond_b     (b_eff),
    .carry_seed (cin)
  );

  subcmp_ripple_add #(.W(W)) u_add (
    .x    (op_a),
    .y    (b_eff),
    .cin  (cin),
    .s    (result),
    .cout (carry_out)
  );

  subcmp_flag_decode #(.W(W)) u_flags (
    .diff    (result),
    .cout    (carry_out),
    .enable  (sub_mode),
    .is_zero (diff_zero),
    .flags   (flags)
  );

  assign a_gt_b = flags.gt;
  assign a_lt_b = flags.lt;
  assign a_eq_b = flags.eq;
endmodule

// File: rtl/subcmp_unit_chk.sv
module subcmp_unit_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sub_mode,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         a_gt_b,
  input logic         a_lt_b,
  input logic         a_eq_b,
  input logic [W-1:0] b_eff,
  input logic         cin,
  input logic         diff_zero
);
  logic [W:0] wide_sum;
  assign wide_sum = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    if (!sub_mode) begin
      p_add_sum_r1: assert ({carry_out, result} == wide_sum);
      p_flags_low_r7: assert (!a_gt_b && !a_lt_b && !a_eq_b);
      p_pass_b_r8: assert (b_eff == op_b && !cin);
    end else begin
      p_diff_r2: assert (result == W'(op_a - op_b) && cin && carry_out == (op_a >= op_b));
      p_eq_r3: assert (a_eq_b == (op_a == op_b) && diff_zero == a_eq_b);
      p_lt_r4: assert (a_lt_b == !carry_out && a_lt_b == (op_a < op_b));
      p_gt_r5: assert (a_gt_b == (op_a > op_b));
      p_one_flag_r6: assert ($countones({a_gt_b, a_lt_b, a_eq_b}) == 1);
    end
  end
endmodule

bind subcmp_unit subcmp_unit_chk #(.W(W)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .sub_mode  (sub_mode),
  .result    (result),
  .carry_out (carry_out),
  .a_gt_b    (a_gt_b),
  .a_lt_b    (a_lt_b),
  .a_eq_b    (a_eq_b),
  .b_eff     (b_eff),
  .cin       (cin),
  .diff_zero (diff_zero)
);

// File: tb/subcmp_unit_bench.sv
module subcmp_unit_bench;
  localparam int W  = 4;
  localparam int WW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [W-1:0]  a, b, res;
  logic          m, co, gt, lt, eq;
  logic [WW-1:0] a2, b2, res2;
  logic          m2, co2, gt2, lt2, eq2;

  subcmp_unit #(.W(W)) u_subcmp_unit (
    .op_a(a), .op_b(b), .sub_mode(m), .result(res), .carry_out(co),
    .a_gt_b(gt), .a_lt_b(lt), .a_eq_b(eq)
  );

  subcmp_unit #(.W(WW)) u_wide (
    .op_a(a2), .op_b(b2), .sub_mode(m2), .result(res2), .carry_out(co2),
    .a_gt_b(gt2), .a_lt_b(lt2), .a_eq_b(eq2)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic only.
  task automatic compare(input int width, input int ia, input int ib, input bit mode,
                         input int r, input bit c, input bit g, input bit l, input bit e);
    int modv, er, ec;
    modv = 1 << width;
    if (!mode) begin
      er = (ia + ib) % modv;
      ec = (ia + ib) / modv;
      check(r == er, "R1 sum", r, er);
      check(c == ec[0], "R1 carry", c, ec);
      check({g, l, e} == 3'b000, "R7 flags in add mode", {g, l, e}, 0);
    end else begin
      er = (ia - ib + modv) % modv;
      check(r == er, "R2 difference", r, er);
      check(c == (ia >= ib), "R2 carry", c, ia >= ib);
      check(e == (ia == ib), "R3 equal", e, ia == ib);
      check(l == (ia < ib), "R4 less", l, ia < ib);
      check(g == (ia > ib), "R5 greater", g, ia > ib);
      check(g + l + e == 1, "R6 one flag", g + l + e, 1);
    end
  endtask

  task automatic apply(input int ia, input int ib, input bit mode);
    @(negedge clk);
    a = W'(ia); b = W'(ib); m = mode;
    @(posedge clk); #1;
    compare(W, ia, ib, mode, int'(res), co, gt, lt, eq);
  endtask

  task automatic apply_wide(input int ia, input int ib, input bit mode);
    @(negedge clk);
    a2 = WW'(ia); b2 = WW'(ib); m2 = mode;
    @(posedge clk); #1;
    compare(WW, ia, ib, mode, int'(res2), co2, gt2, lt2, eq2);  // R8 wider instance
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; m = 1'b0;
    a2 = '0; b2 = '0; m2 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // Idle state: zero operands in add mode give zero result, no carry, no flags.
    check(res == '0 && !co, "R1 idle result", {co, res}, 0);
    check({gt, lt, eq} == 3'b000, "R7 idle flags", {gt, lt, eq}, 0);

    // Exhaustive sweep at the default width, both modes.
    for (int mode = 0; mode < 2; mode++)
      for (int ia = 0; ia < (1 << W); ia++)
        for (int ib = 0; ib < (1 << W); ib++)
          apply(ia, ib, mode[0]);

    // R8: boundaries and random pairs at a wider width.
    for (int mode = 0; mode < 2; mode++) begin
      apply_wide(0, (1 << WW) - 1, mode[0]);
      apply_wide((1 << WW) - 1, 0, mode[0]);
      apply_wide((1 << WW) - 1, (1 << WW) - 1, mode[0]);
      apply_wide((1 << WW) - 2, (1 << WW) - 1, mode[0]);
      apply_wide(1, 0, mode[0]);
      apply_wide(0, 0, mode[0]);
      for (int k = 0; k < 200; k++)
        apply_wide(int'($urandom % (1 << WW)), int'($urandom % (1 << WW)), mode[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule